// File: doc/BRIEF.md
# Selectable-Span Cycle Interrupt Timer

This block is a down-counting timer clocked by CPU cycles that raises an interrupt request. Software sets a 16-bit reload value four bits at a time, copies it into the counter with a separate write, and then arms the timer with a control write. The control write also picks a mode, which sets the effective counter width. In the full-width mode the request fires when the count runs out. In the narrower modes it fires as soon as a decrement borrows out of the low 12, 8 or 4 bits. This gives a coarse interval without the need to program the low bits.

When the request fires, the counter is forced to zero and the timer disarms itself. The request stays high until software writes the control register again. Bank switching and every other address decode are outside this block. It sees only the CPU write bus and a one-cycle strobe that marks each CPU cycle.

The control sequencer has three states. ST_IDLE means disarmed with no request. ST_ARMED means counting is allowed. ST_FIRED means disarmed with the request held. The transitions are:
- arm: ST_IDLE to ST_ARMED, on a control write with bit 0 set.
- disarm: ST_ARMED to ST_IDLE, on a control write with bit 0 clear.
- expire: ST_ARMED to ST_FIRED, when the fire condition holds.
- ack_arm: ST_FIRED to ST_ARMED, on a control write with bit 0 set.
- ack_idle: ST_FIRED to ST_IDLE, on a control write with bit 0 clear.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the counter and the reload value both hold 0xFFFF, the timer is disarmed in mode 0 and `irq` is low. Arming in mode 0 with no reload makes `irq` rise on the 65535th cycle strobe.
- R2: Writes to 0xE000, 0xE001, 0xE002 and 0xE003 place `wr_data[3:0]` into reload bits 3:0, 7:4, 11:8 and 15:12 respectively. All other reload bits are kept, and `wr_data[7:4]` is ignored.
- R3: A write to 0xF000 copies the whole reload value into the counter, whatever the data byte.
- R4: A write to 0xF001 sets the arm bit from `wr_data[0]` and the mode from `wr_data[3:1]`. It always drops `irq` on the next cycle.
- R5: The counter drops by one on each clock where `cpu_tick` is high, but only while armed and nonzero. It never wraps below zero.
- R6: In mode 0 the request fires on the strobe that brings the counter to zero.
- R7: In mode 1 the request fires on the decrement that changes counter bits 15:12. A count that starts below 0x1000 runs to zero without firing.
- R8: In modes 2 and 3 the request fires on the decrement that changes counter bits 15:8.
- R9: In modes 4 to 7 the request fires on the decrement that changes counter bits 15:4.
- R10: Firing zeroes the counter, disarms the timer and raises `irq` one clock after the strobe. `irq` then stays high until a write to 0xF001. Re-arming without a reload causes no counting.
- R11: A write to 0xF000 or 0xF001 in the same clock as `cpu_tick` takes priority, and that strobe does not decrement the counter.
- R12: Writes to any other address change neither the reload value, the counter, the arm state nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-clock strobe per CPU cycle |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The counter and the reload value are hidden, so any fault in them shows at the ports only as `irq` rising on the wrong strobe. Examples are a dropped nibble, a wrong mode mask, or a decrement taken during a write. The bench therefore loads chosen reload values that put each mode's borrow point a few strobes away, and checks the strobe before the expected edge as well as the edge itself. An error in the sequencer shows within one clock: a request that fails to clear after the control write, or one that reappears after re-arming with a zero count.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SPAN_FULL = 2'd0,
        SPAN_HI4  = 2'd1,
        SPAN_HI8  = 2'd2,
        SPAN_HI12 = 2'd3
    } span_e;

    // mode code -> watched span: 0 full, 1 top nibble, 2-3 top byte, 4-7 top 12 bits
    function automatic span_e mode_to_span(input logic [2:0] mode);
        span_e s;
        unique case (mode)
            3'd0:         s = SPAN_FULL;
            3'd1:         s = SPAN_HI4;
            3'd2, 3'd3:   s = SPAN_HI8;
            default:      s = SPAN_HI12;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode #(
    parameter int          ADDR_W      = 16,
    parameter int          NIBS        = 4,
    parameter logic [15:0] LATCH_BASE  = 16'hE000,
    parameter logic [15:0] RELOAD_ADDR = 16'hF000,
    parameter logic [15:0] CTRL_ADDR   = 16'hF001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NIBS-1:0]   nib_we,
    output logic              reload_we,
    output logic              ctrl_we
);

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        localparam logic [ADDR_W-1:0] NIB_ADDR = ADDR_W'(LATCH_BASE) + ADDR_W'(g);
        assign nib_we[g] = wr_en && (wr_addr == NIB_ADDR);
    end

    assign reload_we = wr_en && (wr_addr == ADDR_W'(RELOAD_ADDR));
    assign ctrl_we   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

endmodule

// File: rtl/cyc_irq_latch.sv
module cyc_irq_latch #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    localparam int VAL_W = NIB_W * NIBS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIBS-1:0]  nib_we,
    input  logic [NIB_W-1:0] nib_data,
    output logic [VAL_W-1:0] value
);

    for (genvar g = 0; g < NIBS; g++) begin : g_slice
        logic [NIB_W-1:0] slice_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slice_q <= '1;
            end else if (nib_we[g]) begin
                slice_q <= nib_data;
            end
        end
        assign value[g*NIB_W +: NIB_W] = slice_q;
    end

endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count
    import cyc_irq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOW_A  = 12,
    parameter int LOW_B  = 8,
    parameter int LOW_C  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  span_e            span,
    output logic [CNT_W-1:0] count,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONES   = '1;
    localparam logic [CNT_W-1:0] MASK_A = ONES << LOW_A;
    localparam logic [CNT_W-1:0] MASK_B = ONES << LOW_B;
    localparam logic [CNT_W-1:0] MASK_C = ONES << LOW_C;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_dec;
    logic             nonzero;
    logic             hit;

    assign nonzero   = (count_q != '0);
    assign count_dec = count_q - 1'b1;

    always_comb begin
        unique case (span)
            SPAN_FULL: hit = (count_dec == '0);
            SPAN_HI4:  hit = ((count_dec ^ count_q) & MASK_A) != '0;
            SPAN_HI8:  hit = ((count_dec ^ count_q) & MASK_B) != '0;
            SPAN_HI12: hit = ((count_dec ^ count_q) & MASK_C) != '0;
            default:   hit = 1'b0;
        endcase
    end

    assign fire = step && nonzero && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (load) begin
            count_q <= load_val;
        end else if (fire) begin
            count_q <= '0;
        end else if (step && nonzero) begin
            count_q <= count_dec;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl
    import cyc_irq_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ctrl_arm,
    input  logic [MODE_W-1:0] ctrl_mode,
    input  logic              fire,
    output logic [MODE_W-1:0] mode,
    output logic              armed,
    output logic              irq
);

    tmr_state_e state_q;
    tmr_state_e state_d;
    logic [MODE_W-1:0] mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_we && ctrl_arm) state_d = ST_ARMED;          // arm
            end
            ST_ARMED: begin
                if (ctrl_we)   state_d = ctrl_arm ? ST_ARMED : ST_IDLE; // disarm
                else if (fire) state_d = ST_FIRED;                      // expire
            end
            ST_FIRED: begin
                if (ctrl_we) state_d = ctrl_arm ? ST_ARMED : ST_IDLE;   // ack_arm / ack_idle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ctrl_we) mode_q <= ctrl_mode;
        end
    end

    always_comb begin
        armed = 1'b0;
        irq   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: armed = 1'b1;
            ST_FIRED: irq   = 1'b1;
            default:  ;
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_irq_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          NIB_W       = 4,
    parameter int          NIBS        = 4,
    parameter int          MODE_W      = 3,
    parameter logic [15:0] LATCH_BASE  = 16'hE000,
    parameter logic [15:0] RELOAD_ADDR = 16'hF000,
    parameter logic [15:0] CTRL_ADDR   = 16'hF001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);

    localparam int CNT_W = NIB_W * NIBS;

    logic [NIBS-1:0]   nib_we;
    logic              reload_we;
    logic              ctrl_we;
    logic [CNT_W-1:0]  lat_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MODE_W-1:0] mode;
    logic              armed;
    logic              fire;
    logic              step;
    logic              unused_data;

    assign unused_data = ^wr_data[DATA_W-1:MODE_W+1];

    cyc_irq_decode #(
        .ADDR_W(ADDR_W), .NIBS(NIBS), .LATCH_BASE(LATCH_BASE),
        .RELOAD_ADDR(RELOAD_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) decode_i (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .nib_we(nib_we), .reload_we(reload_we), .ctrl_we(ctrl_we)
    );

    cyc_irq_latch #(.NIB_W(NIB_W), .NIBS(NIBS)) latch_i (
        .clk(clk), .rst_n(rst_n), .nib_we(nib_we),
        .nib_data(wr_data[NIB_W-1:0]), .value(lat_q)
    );

    // a reload or control write wins over the cycle strobe
    assign step = armed && cpu_tick && !reload_we && !ctrl_we;

    cyc_irq_count #(.CNT_W(CNT_W), .LOW_A(CNT_W-4), .LOW_B(CNT_W-8), .LOW_C(CNT_W-12)) count_i (
        .clk(clk), .rst_n(rst_n), .load(reload_we), .load_val(lat_q),
        .step(step), .span(mode_to_span(mode)), .count(cnt_q), .fire(fire)
    );

    cyc_irq_ctrl #(.MODE_W(MODE_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_arm(wr_data[0]),
        .ctrl_mode(wr_data[MODE_W:1]), .fire(fire),
        .mode(mode), .armed(armed), .irq(irq)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_tick,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        irq,
    input logic [15:0] cnt,
    input logic [15:0] lat,
    input logic        armed
);

    logic ctrl_w, reload_w;
    assign ctrl_w   = wr_en && (wr_addr == 16'hF001);
    assign reload_w = wr_en && (wr_addr == 16'hF000);

    assert_reload_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_w |=> cnt == $past(lat));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w |=> !irq);

    assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_w) |=> irq);

    assert_fire_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt == 16'h0000 && !armed));

    assert_fire_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_tick));

    assert_no_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload_w) |=> $stable(cnt));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && !reload_w) |=> $stable(cnt));

    assert_one_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, armed}));

endmodule

bind cyc_irq_timer cyc_irq_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
    .cnt(cnt_q), .lat(lat_q), .armed(armed)
);

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cyc_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk = 1'b0);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cpu_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; cpu_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_tick = 1'b1;
            @(negedge clk);
        end
        cpu_tick = 1'b0;
    endtask

    // R2: upper data nibble carries junk that must be ignored
    task automatic set_latch(input logic [15:0] v);
        for (int k = 0; k < 4; k++) wr(16'hE000 + 16'(k), {4'hA, v[k*4 +: 4]});
    endtask

    // load, arm, then expect irq on exactly strobe n
    task automatic expect_fire(input string req, input logic [15:0] v, input logic [7:0] ctl, input int n);
        set_latch(v);
        wr(16'hF000, 8'h5A);
        wr(16'hF001, ctl);
        ticks(n - 1);
        check(req, irq, 1'b0);
        ticks(1);
        check(req, irq, 1'b1);
        wr(16'hF001, 8'h00);
        check("R4", irq, 1'b0);
    endtask

    task automatic t_reset;
        check("R1", irq, 1'b0);
        wr(16'hF001, 8'h01);
        ticks(65534);
        check("R1", irq, 1'b0);
        ticks(1);
        check("R1", irq, 1'b1);
        ticks(5);
        check("R10", irq, 1'b1);
    endtask

    task automatic t_ack_no_recount;
        wr(16'hF001, 8'h01);
        check("R4", irq, 1'b0);
        ticks(20);
        check("R10", irq, 1'b0);
        wr(16'hF001, 8'h00);
    endtask

    task automatic t_modes;
        expect_fire("R6", 16'h0005, 8'h01, 5);
        expect_fire("R7", 16'h1005, 8'h03, 6);
        expect_fire("R8", 16'h0203, 8'h05, 4);
        expect_fire("R8", 16'h0203, 8'h07, 4);
        expect_fire("R9", 16'h0012, 8'h09, 3);
        expect_fire("R9", 16'h0012, 8'h0B, 3);
        expect_fire("R9", 16'h0012, 8'h0D, 3);
        expect_fire("R9", 16'h0012, 8'h0F, 3);
    endtask

    task automatic t_mode1_below;
        set_latch(16'h0005);
        wr(16'hF000, 8'h00);
        wr(16'hF001, 8'h03);
        ticks(30);
        check("R7", irq, 1'b0);
        wr(16'hF001, 8'h00);
    endtask

    task automatic t_partial;
        set_latch(16'h0012);
        wr(16'hE000, 8'hF7);          // latch becomes 0x0017
        wr(16'hF000, 8'hFF);
        wr(16'hF001, 8'h09);
        ticks(7);
        check("R2", irq, 1'b0);
        ticks(1);
        check("R2", irq, 1'b1);
        wr(16'hF001, 8'h00);
    endtask

    task automatic t_disable;
        set_latch(16'h0005);
        wr(16'hF000, 8'h00);
        wr(16'hF001, 8'h01);
        ticks(2);
        wr(16'hF001, 8'h00);
        ticks(10);
        check("R5", irq, 1'b0);
        wr(16'hF001, 8'h01);
        ticks(2);
        check("R5", irq, 1'b0);
        ticks(1);
        check("R5", irq, 1'b1);
        wr(16'hF001, 8'h00);
    endtask

    task automatic t_collide;
        set_latch(16'h0005);
        wr(16'hF000, 8'h00);
        wr(16'hF001, 8'h01);
        ticks(2);
        wr(16'hF001, 8'h01, 1'b1);    // strobe must not count
        ticks(2);
        check("R11", irq, 1'b0);
        ticks(1);
        check("R11", irq, 1'b1);
        wr(16'hF001, 8'h00);
    endtask

    task automatic t_ignored;
        set_latch(16'h0005);
        wr(16'hE004, 8'h0F);
        wr(16'hDFFF, 8'h0F);
        wr(16'hF000, 8'h00);
        wr(16'hF002, 8'h01);          // not the control address: stays disarmed
        ticks(8);
        check("R12", irq, 1'b0);
        wr(16'hF001, 8'h01);
        ticks(4);
        check("R12", irq, 1'b0);
        ticks(1);
        check("R12", irq, 1'b1);
        wr(16'hF003, 8'h00);
        check("R12", irq, 1'b1);
        wr(16'hF001, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack_no_recount();
        t_modes();
        t_mode1_below();
        t_partial();
        t_disable();
        t_collide();
        t_ignored();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule